// File: doc/BRIEF.md
# Xoshiro128++ Random Word Stream

This block produces pseudo-random 32-bit words with the xoshiro128++ generator. The generator keeps a 128-bit state split into four 32-bit lanes. The words leave the block on a valid/ready stream. A 128-bit default seed is fixed by a parameter and is loaded on synchronous reset. At run time a one-cycle reseed strobe loads a new 128-bit seed.

After reset or reseed the block spends one cycle preparing the first word from the new state, and `word_valid` is low during that cycle. From then on `word_valid` stays high. Back-pressure follows the usual stream rules. A word is consumed on every rising edge where `word_valid` and `word_ready` are both high, and the next word appears in the same edge. When `word_ready` is low, the presented word and `word_valid` hold for as many cycles as the stall lasts. The output word is held in a register, so nothing combinational runs from `word_ready` to `word_data`.

Top module: `prng_x128pp_stream`

## Requirements
- R1: While `rst` is high at a rising edge, `word_valid` is 0 and `word_data` is 0 after that edge.
- R2: At the first rising edge with `rst` low after a reset, `word_valid` becomes 1 and `word_data` shows the word of the default seed.
- R3: The seed is split into lanes with s0 = bits [127:96], s1 = [95:64], s2 = [63:32] and s3 = [31:0]. The word of a state is rotl32(s0 + s3, 7) + s0, with all sums taken modulo 2^32.
- R4: A consumed word moves the state forward by the following steps, in this order: t = s1 << 9; s2 ^= s0; s3 ^= s1; s1 ^= s2; s0 ^= s3; s2 ^= t; s3 = rotl32(s3, 11). The word that follows is the word of the new state.
- R5: Once `word_valid` is high, it stays high on every cycle until the next reset or reseed. The state moves forward only on edges where `word_valid` and `word_ready` are both high, so a steady `word_ready` gives one new word per cycle.
- R6: While `word_ready` is low and `word_valid` is high, `word_data` does not change and `word_valid` stays high, for stalls of any length.
- R7: A reseed pulse at a rising edge loads `seed_in` as the state and drops `word_valid` to 0 for one cycle. At the following edge `word_valid` returns to 1 with the word of the loaded seed.
- R8: When `rst` and `reseed` are both high at an edge, reset wins. The first word afterwards comes from the default seed.
- R9: When `reseed` comes at an edge where a word would otherwise be consumed, the reseed wins. The sequence restarts at the first word of the new seed.
- R10: `seed_in` has no effect while `reseed` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads the default seed |
| reseed | input | 1 | One-cycle strobe that loads `seed_in` as the new state |
| seed_in | input | 128 | Seed value, sampled only while `reseed` is high |
| word_ready | input | 1 | Consumer accepts the presented word |
| word_valid | output | 1 | A word is presented on `word_data` |
| word_data | output | 32 | Current random word |

## Verification
Every result in this block is due exactly one rising edge after the stimulus that causes it. The bench drives inputs and samples outputs only at falling edges, so each check reads the result of exactly one rising edge.
- The first word after reset release is due at the next edge.
- After a reseed, the low `word_valid` is due one edge later and the new seed's word one edge after that.
- A consumed word is replaced at the edge where it is accepted.
- During a stall the word seen at each falling edge must equal the word seen at the one before.

A bench-side model steps its own state only when it has driven `word_ready` high while `word_valid` was high. Each sample is compared with that model.

// File: rtl/x128pp_pkg.sv
package x128pp_pkg;

  localparam int unsigned LANE_W  = 32;
  localparam int unsigned LANES   = 4;
  localparam int unsigned STATE_W = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;

  // First member occupies the most significant lane of a packed seed.
  typedef struct packed {
    lane_t s0;
    lane_t s1;
    lane_t s2;
    lane_t s3;
  } gen_state_t;

  typedef enum logic {
    PH_PREP = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  function automatic lane_t rotl(input lane_t v, input int unsigned k);
    return (v << k) | (v >> (LANE_W - k));
  endfunction

endpackage

// File: rtl/x128pp_step.sv
module x128pp_step
  import x128pp_pkg::*;
#(
  parameter int unsigned SHIFT_T = 9,
  parameter int unsigned ROT_S3  = 11
) (
  input  gen_state_t cur,
  output gen_state_t nxt
);

  lane_t t_lane;
  lane_t a, b, c, d;

  always_comb begin
    t_lane = cur.s1 << SHIFT_T;
    a = cur.s0;
    b = cur.s1;
    c = cur.s2;
    d = cur.s3;
    c = c ^ a;
    d = d ^ b;
    b = b ^ c;
    a = a ^ d;
    c = c ^ t_lane;
    d = rotl(d, ROT_S3);
    nxt = '{s0: a, s1: b, s2: c, s3: d};
  end

endmodule

// File: rtl/x128pp_mix.sv
module x128pp_mix
  import x128pp_pkg::*;
#(
  parameter int unsigned ROT_OUT = 7
) (
  input  gen_state_t st,
  output lane_t      word
);

  lane_t sum;

  always_comb begin
    sum  = st.s0 + st.s3;
    word = rotl(sum, ROT_OUT) + st.s0;
  end

endmodule

// File: rtl/x128pp_state.sv
module x128pp_state
  import x128pp_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = 128'h0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  gen_state_t load_val,
  input  logic       adv,
  input  gen_state_t nxt,
  output gen_state_t st
);

  localparam gen_state_t SEED_ST = gen_state_t'(SEED);

  always_ff @(posedge clk) begin
    if (rst)       st <= SEED_ST;
    else if (load) st <= load_val;
    else if (adv)  st <= nxt;
  end

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(st));

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (st == $past(load_val)));

endmodule

// File: rtl/prng_x128pp_stream.sv
module prng_x128pp_stream
  import x128pp_pkg::*;
#(
  parameter logic [127:0] SEED    = 128'h0123456789abcdef3141592653589793,
  parameter int unsigned  ROT_OUT = 7,
  parameter int unsigned  SHIFT_T = 9,
  parameter int unsigned  ROT_S3  = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  logic [127:0] seed_in,
  input  logic         word_ready,
  output logic         word_valid,
  output logic [31:0]  word_data
);

  gen_state_t cur_st, nxt_st;
  lane_t      word_cur, word_nxt;
  phase_e     phase;
  logic       fire, adv;

  assign word_valid = (phase == PH_RUN);
  assign fire       = word_valid & word_ready;
  assign adv        = fire & ~reseed;

  x128pp_step #(.SHIFT_T(SHIFT_T), .ROT_S3(ROT_S3)) u_step (
    .cur (cur_st),
    .nxt (nxt_st)
  );

  x128pp_state #(.SEED(SEED)) u_state (
    .clk      (clk),
    .rst      (rst),
    .load     (reseed),
    .load_val (gen_state_t'(seed_in)),
    .adv      (adv),
    .nxt      (nxt_st),
    .st       (cur_st)
  );

  x128pp_mix #(.ROT_OUT(ROT_OUT)) u_mix_cur (
    .st   (cur_st),
    .word (word_cur)
  );

  x128pp_mix #(.ROT_OUT(ROT_OUT)) u_mix_nxt (
    .st   (nxt_st),
    .word (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PREP;
      word_data <= '0;
    end else if (reseed) begin
      phase     <= PH_PREP;
    end else if (phase == PH_PREP) begin
      phase     <= PH_RUN;
      word_data <= word_cur;
    end else if (fire) begin
      word_data <= word_nxt;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready && !reseed) |=> (word_valid && $stable(word_data)));

  // R7
  reseed_drop_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> !word_valid);

  // R2
  prep_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_valid && !reseed) |=> word_valid);

  // R5
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !reseed) |=> word_valid);

endmodule

// File: tb/tb_prng_x128pp_stream.sv
`timescale 1ns/1ps
module tb_prng_x128pp_stream;

  localparam logic [127:0] DEF_SEED = 128'h0123456789abcdef3141592653589793;

  logic         clk = 1'b0;
  logic         rst, reseed, word_ready;
  logic [127:0] seed_in;
  logic         word_valid;
  logic [31:0]  word_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [127:0] m;

  always #10 clk = ~clk;

  prng_x128pp_stream #(.SEED(DEF_SEED)) dut (
    .clk(clk), .rst(rst), .reseed(reseed), .seed_in(seed_in),
    .word_ready(word_ready), .word_valid(word_valid), .word_data(word_data)
  );

  function automatic logic [31:0] r7(input logic [31:0] x);
    return {x[24:0], x[31:25]};
  endfunction
  function automatic logic [31:0] r11(input logic [31:0] x);
    return {x[20:0], x[31:21]};
  endfunction
  function automatic logic [31:0] mword(input logic [127:0] s);
    logic [31:0] a, q;
    a = s[127:96];
    q = a + s[31:0];
    return r7(q) + a;
  endfunction
  function automatic logic [127:0] mnext(input logic [127:0] s);
    logic [31:0] a, b, c, d, t;
    a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0];
    t = {b[22:0], 9'd0};
    c ^= a; d ^= b; b ^= c; a ^= d; c ^= t; d = r11(d);
    return {a, b, c, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      finish_up();
    end
  end

  // R1, R2, R3
  task automatic t_reset();
    rst = 1; reseed = 0; word_ready = 0; seed_in = '0;
    repeat (2) @(negedge clk);
    chk("R1 valid", {31'd0, word_valid}, 32'd0);
    chk("R1 data", word_data, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R2 valid", {31'd0, word_valid}, 32'd1);
    chk("R3 first word", word_data, mword(DEF_SEED));
    m = DEF_SEED;
  endtask

  // R4, R5, R6: mode 0 always ready, 1 single stalls, 2 long stalls
  task automatic t_stream(input int n, input int mode);
    logic prev_rdy = 1'b1;
    for (int i = 0; i < n; i++) begin
      chk("R5 valid", {31'd0, word_valid}, 32'd1);
      chk(prev_rdy ? "R4 word" : "R6 stall hold", word_data, mword(m));
      case (mode)
        0: word_ready = 1;
        1: word_ready = (i % 3) != 1;
        default: word_ready = (i % 7) > 3;
      endcase
      prev_rdy = word_ready;
      if (word_ready) m = mnext(m);
      @(negedge clk);
    end
  endtask

  // R7, R9
  task automatic t_reseed(input logic [127:0] s, input logic rdy);
    reseed = 1; seed_in = s; word_ready = rdy;
    @(negedge clk);
    chk("R7 valid low", {31'd0, word_valid}, 32'd0);
    reseed = 0; seed_in = ~s;
    @(negedge clk);
    chk("R7 valid back", {31'd0, word_valid}, 32'd1);
    chk(rdy ? "R9 reseed wins" : "R7 new seed word", word_data, mword(s));
    m = s;
    word_ready = 0;
  endtask

  // R8
  task automatic t_rst_and_reseed();
    rst = 1; reseed = 1; seed_in = 128'hfeedface_0badf00d_13579bdf_2468ace0;
    @(negedge clk);
    rst = 0; reseed = 0;
    @(negedge clk);
    chk("R8 reset wins", word_data, mword(DEF_SEED));
    m = DEF_SEED;
  endtask

  // R10
  task automatic t_ignore_seed();
    word_ready = 0;
    for (int i = 0; i < 4; i++) begin
      seed_in = {4{32'h9e3779b9 + i}};
      @(negedge clk);
      chk("R10 seed ignored", word_data, mword(m));
    end
    t_stream(6, 0);
  endtask

  initial begin
    t_reset();
    t_stream(40, 0);
    t_stream(60, 1);
    t_stream(60, 2);
    t_reseed(128'h3141592653589793fedcba9876543210, 1'b0);
    t_stream(40, 1);
    t_reseed(128'h00000001_00000000_00000000_80000000, 1'b1);
    t_stream(40, 2);
    t_ignore_seed();
    t_rst_and_reseed();
    t_stream(20, 0);
    finish_up();
  end

endmodule